// File: doc/BRIEF.md
# Tenant-Partitioned Scratchpad Guard with Region Zeroizer

This block sits in front of an on-chip scratchpad that is shared by up to four mutually distrusting tenants. The scratchpad is carved into equal, fixed-size regions. A region map records, for each region, whether it is held and by which tenant. Every read or write arrives tagged with a tenant ID and a word address. The guard lets the access through only when two conditions hold: the region is held by that same tenant, and the region lies inside the tenant's configured base..limit window. A refused read returns zero. A refused write leaves memory untouched. Either refusal raises a violation flag that carries the offending tenant ID.

A tenant takes a region through a claim request, which succeeds only on a free region. A clear command names a first and last region. The sequencer then writes zeros over that span at one word per clock. In teardown mode it also releases the region map entries once the last word is written. While the clear runs, any access that targets a region in the span is stalled at the request port until the clear is finished. Accesses to other regions continue as normal.

Top module: `spm_guard`

## Requirements
- R1: After reset no region is held, memory reads as zero, and claim_ack, claim_nack, acc_rvalid, viol_valid, zero_busy and zero_done are all low.
- R2: A claim for a free region raises claim_ack one cycle later and records the tenant as holder. A claim for a region that is already held raises claim_nack one cycle later and leaves the holder as it was.
- R3: An access is allowed when the addressed region (address bits above the in-region word offset) is held by the requesting tenant and lies within that tenant's base..limit. An allowed write stores the data. An allowed read returns the stored word on acc_rdata, with acc_rvalid high, one cycle later.
- R4: An access to a region that is free or held by another tenant is refused. A refused read returns zero with acc_rvalid high. A refused write leaves the memory unchanged. In both cases viol_valid rises one cycle later, and viol_tenant equals the requesting tenant.
- R5: An access by the holder to a region outside that tenant's base..limit window is refused in the same way as R4.
- R6: An accepted clear of regions first..last keeps zero_busy high for exactly (last-first+1) times the words per region cycles, writing one word per cycle. zero_done pulses for one cycle in the cycle in which zero_busy falls.
- R7: After a clear without teardown, every word in the span reads as zero and the regions keep their holders.
- R8: After a clear with teardown, the span's regions are free. A later read by the former holder returns zero and is flagged, and another tenant can claim the region.
- R9: An access to a region inside the span of a running or just-accepted clear holds acc_stall high, and it produces neither acc_rvalid nor viol_valid. Accesses outside the span are not stalled.
- R10: A clear request is ignored while a clear is running, and it is ignored when first is greater than last.
- R11: Tenant IDs are two bits wide, so tenants 0 to 3 each have an independent base..limit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tenant_base | input | NUM_TENANTS*RIW | Per-tenant lowest permitted region, packed with tenant 0 in the low bits |
| tenant_limit | input | NUM_TENANTS*RIW | Per-tenant highest permitted region, packed in the same way |
| claim_valid | input | 1 | Claim request strobe |
| claim_tenant | input | TW | Tenant requesting the region |
| claim_region | input | RIW | Region to claim |
| claim_ack | output | 1 | Claim granted (one cycle after the request) |
| claim_nack | output | 1 | Claim refused because the region is held |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_tenant | input | TW | Requesting tenant |
| acc_addr | input | AW | Word address: region index in the upper bits, word offset in the lower bits |
| acc_wdata | input | DATA_W | Write data |
| acc_stall | output | 1 | Access held off by a clear in progress |
| acc_rvalid | output | 1 | Read response valid |
| acc_rdata | output | DATA_W | Read data, or zero when refused |
| viol_valid | output | 1 | Refused access flag |
| viol_tenant | output | TW | Tenant of the refused access |
| zero_start | input | 1 | Clear request strobe |
| zero_first | input | RIW | First region to clear |
| zero_last | input | RIW | Last region to clear |
| zero_teardown | input | 1 | Also release the region map entries at the end of the clear |
| zero_busy | output | 1 | Clear in progress |
| zero_done | output | 1 | One-cycle pulse when the last word has been cleared |

## Verification
The bench builds the block with eight regions of four 16-bit words and the full four tenants. Short regions keep every clear to a few dozen cycles, so the exact busy length, the done pulse and stalls both inside and outside the span can all be checked in a single run. The tenant windows are chosen to overlap: one tenant spans the whole memory, and another holds a region that lies outside its own window. As a result, random traffic reaches the ownership refusal, the bounds refusal and the allowed path all in comparable numbers.

// File: rtl/spm_guard_pkg.sv
// Package: shared types for the scratchpad guard.
// Holds the clear-sequencer state encoding. It assumes nothing about the
// width parameters of the block.
package spm_guard_pkg;
    typedef enum logic [0:0] {
        ZS_IDLE = 1'b0,
        ZS_RUN  = 1'b1
    } zero_state_t;
endpackage

// File: rtl/spm_owner_map.sv
// Region map: one holder entry per region, each with a valid bit and a tenant ID.
// A claim is granted only on a free region. A teardown clear releases a span of
// regions and takes priority over a claim in the same cycle.
// Assumes at most one claim per cycle.
module spm_owner_map #(
    parameter int REGIONS = 8,
    parameter int TW      = 2,
    parameter int RIW     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 claim_valid,
    input  logic [TW-1:0]        claim_tenant,
    input  logic [RIW-1:0]       claim_region,
    input  logic                 clr_en,
    input  logic [RIW-1:0]       clr_first,
    input  logic [RIW-1:0]       clr_last,
    output logic [REGIONS-1:0]   held,
    output logic [REGIONS*TW-1:0] holder,
    output logic                 claim_ack,
    output logic                 claim_nack
);
    logic clr_hits_claim;
    logic grant;

    // Purpose: decide whether this cycle's claim can be granted.
    always_comb begin
        clr_hits_claim = clr_en && (claim_region >= clr_first) && (claim_region <= clr_last);
        grant = claim_valid && !held[claim_region] && !clr_hits_claim;
    end

    for (genvar i = 0; i < REGIONS; i++) begin : g_entry
        localparam logic [RIW-1:0] IDX = RIW'(i);
        // Purpose: update one region's holder entry on a claim or a release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[i]                 <= 1'b0;
                holder[i*TW +: TW]      <= '0;
            end else if (clr_en && (IDX >= clr_first) && (IDX <= clr_last)) begin
                held[i]                 <= 1'b0;
                holder[i*TW +: TW]      <= '0;
            end else if (grant && (claim_region == IDX)) begin
                held[i]                 <= 1'b1;
                holder[i*TW +: TW]      <= claim_tenant;
            end
        end
    end

    // Purpose: register the claim response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_ack  <= 1'b0;
            claim_nack <= 1'b0;
        end else begin
            claim_ack  <= grant;
            claim_nack <= claim_valid && !grant;
        end
    end
endmodule

// File: rtl/spm_zero_engine.sv
// Clear sequencer: walks a span of regions and writes one zero word per cycle.
// It pulses done in the cycle in which busy falls. In teardown mode it asks the
// region map to release the span on the final write.
// Also publishes the span it guards, so conflicting accesses can be stalled;
// this includes the cycle in which a request is accepted.
// Assumes REGIONS and WPR are powers of two.
module spm_zero_engine
    import spm_guard_pkg::*;
#(
    parameter int RIW = 3,
    parameter int WOW = 3,
    localparam int AW = RIW + WOW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [RIW-1:0] first,
    input  logic [RIW-1:0] last,
    input  logic           teardown,
    output logic           busy,
    output logic           done,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic           clr_en,
    output logic [RIW-1:0] clr_first,
    output logic [RIW-1:0] clr_last,
    output logic           guard_active,
    output logic [RIW-1:0] guard_first,
    output logic [RIW-1:0] guard_last
);
    zero_state_t    state;
    logic [AW-1:0]  ptr;
    logic [RIW-1:0] first_q, last_q;
    logic           tear_q;
    logic           start_ok;
    logic           at_end;

    // Purpose: derive acceptance, the end-of-span condition and the guarded span.
    always_comb begin
        start_ok     = start && (state == ZS_IDLE) && (first <= last);
        at_end       = (ptr == {last_q, {WOW{1'b1}}});
        busy         = (state == ZS_RUN);
        wr_en        = busy;
        wr_addr      = ptr;
        clr_en       = busy && at_end && tear_q;
        clr_first    = first_q;
        clr_last     = last_q;
        guard_active = busy || start_ok;
        guard_first  = busy ? first_q : first;
        guard_last   = busy ? last_q  : last;
    end

    // Purpose: sequence the clear and raise the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ZS_IDLE;
            ptr     <= '0;
            first_q <= '0;
            last_q  <= '0;
            tear_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ZS_IDLE: begin
                    if (start_ok) begin
                        state   <= ZS_RUN;
                        ptr     <= {first, {WOW{1'b0}}};
                        first_q <= first;
                        last_q  <= last;
                        tear_q  <= teardown;
                    end
                end
                ZS_RUN: begin
                    if (at_end) begin
                        state <= ZS_IDLE;
                        done  <= 1'b1;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                default: state <= ZS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spm_access_check.sv
// Permission and conflict check for a single access (combinational).
// Looks up the addressed region's holder and the requesting tenant's
// base..limit window, and compares the region with the span being cleared.
module spm_access_check #(
    parameter int REGIONS     = 8,
    parameter int NUM_TENANTS = 4,
    parameter int TW          = 2,
    parameter int RIW         = 3,
    parameter int WOW         = 3,
    localparam int AW         = RIW + WOW
) (
    input  logic                      acc_valid,
    input  logic [TW-1:0]             acc_tenant,
    input  logic [AW-1:0]             acc_addr,
    input  logic [REGIONS-1:0]        held,
    input  logic [REGIONS*TW-1:0]     holder,
    input  logic [NUM_TENANTS*RIW-1:0] tenant_base,
    input  logic [NUM_TENANTS*RIW-1:0] tenant_limit,
    input  logic                      guard_active,
    input  logic [RIW-1:0]            guard_first,
    input  logic [RIW-1:0]            guard_last,
    output logic                      allowed,
    output logic                      stall
);
    logic [RIW-1:0] region;
    logic [TW-1:0]  owner;
    logic [RIW-1:0] base, limit;

    // Purpose: decide permission and stall for the current request.
    always_comb begin
        region  = acc_addr[AW-1:WOW];
        owner   = holder[region*TW +: TW];
        base    = tenant_base[acc_tenant*RIW +: RIW];
        limit   = tenant_limit[acc_tenant*RIW +: RIW];
        allowed = held[region] && (owner == acc_tenant) &&
                  (region >= base) && (region <= limit);
        stall   = acc_valid && guard_active &&
                  (region >= guard_first) && (region <= guard_last);
    end
endmodule

// File: rtl/spm_data_array.sv
// Scratchpad storage with registered reads.
// Reset fills it with zeros. A clear write and an access write never target the
// same word, because conflicting accesses are stalled upstream.
// A read with rd_en low returns zero.
module spm_data_array #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zwr_en,
    input  logic [AW-1:0]     zwr_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: apply clear and access writes, and register read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (zwr_en) mem[zwr_addr] <= '0;
            if (wr_en)  mem[addr]     <= wdata;
            rdata <= rd_en ? mem[addr] : '0;
        end
    end
endmodule

// File: rtl/spm_guard.sv
// Top level of the tenant-partitioned scratchpad guard.
// Joins the region map, the access check, the clear sequencer and the storage,
// and registers the access response and violation flags.
// Assumes the requester holds a stalled access until acc_stall falls.
module spm_guard #(
    parameter int NUM_TENANTS = 4,
    parameter int REGIONS     = 8,
    parameter int WPR         = 8,
    parameter int DATA_W      = 32,
    localparam int TW         = $clog2(NUM_TENANTS),
    localparam int RIW        = $clog2(REGIONS),
    localparam int WOW        = $clog2(WPR),
    localparam int AW         = RIW + WOW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TENANTS*RIW-1:0] tenant_base,
    input  logic [NUM_TENANTS*RIW-1:0] tenant_limit,
    input  logic                       claim_valid,
    input  logic [TW-1:0]              claim_tenant,
    input  logic [RIW-1:0]             claim_region,
    output logic                       claim_ack,
    output logic                       claim_nack,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [TW-1:0]              acc_tenant,
    input  logic [AW-1:0]              acc_addr,
    input  logic [DATA_W-1:0]          acc_wdata,
    output logic                       acc_stall,
    output logic                       acc_rvalid,
    output logic [DATA_W-1:0]          acc_rdata,
    output logic                       viol_valid,
    output logic [TW-1:0]              viol_tenant,
    input  logic                       zero_start,
    input  logic [RIW-1:0]             zero_first,
    input  logic [RIW-1:0]             zero_last,
    input  logic                       zero_teardown,
    output logic                       zero_busy,
    output logic                       zero_done
);
    localparam int DEPTH = REGIONS * WPR;

    logic [REGIONS-1:0]    held;
    logic [REGIONS*TW-1:0] holder;
    logic                  clr_en;
    logic [RIW-1:0]        clr_first, clr_last;
    logic                  zwr_en;
    logic [AW-1:0]         zwr_addr;
    logic                  guard_active;
    logic [RIW-1:0]        guard_first, guard_last;
    logic                  allowed, stall;
    logic                  go;

    spm_owner_map #(.REGIONS(REGIONS), .TW(TW), .RIW(RIW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .claim_valid(claim_valid), .claim_tenant(claim_tenant), .claim_region(claim_region),
        .clr_en(clr_en), .clr_first(clr_first), .clr_last(clr_last),
        .held(held), .holder(holder), .claim_ack(claim_ack), .claim_nack(claim_nack)
    );

    spm_zero_engine #(.RIW(RIW), .WOW(WOW)) u_zero (
        .clk(clk), .rst_n(rst_n),
        .start(zero_start), .first(zero_first), .last(zero_last), .teardown(zero_teardown),
        .busy(zero_busy), .done(zero_done), .wr_en(zwr_en), .wr_addr(zwr_addr),
        .clr_en(clr_en), .clr_first(clr_first), .clr_last(clr_last),
        .guard_active(guard_active), .guard_first(guard_first), .guard_last(guard_last)
    );

    spm_access_check #(.REGIONS(REGIONS), .NUM_TENANTS(NUM_TENANTS), .TW(TW),
                       .RIW(RIW), .WOW(WOW)) u_chk_logic (
        .acc_valid(acc_valid), .acc_tenant(acc_tenant), .acc_addr(acc_addr),
        .held(held), .holder(holder),
        .tenant_base(tenant_base), .tenant_limit(tenant_limit),
        .guard_active(guard_active), .guard_first(guard_first), .guard_last(guard_last),
        .allowed(allowed), .stall(stall)
    );

    // Purpose: an access proceeds when it is requested and not stalled.
    always_comb begin
        go        = acc_valid && !stall;
        acc_stall = stall;
    end

    spm_data_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .zwr_en(zwr_en), .zwr_addr(zwr_addr),
        .wr_en(go && acc_write && allowed),
        .rd_en(go && !acc_write && allowed),
        .addr(acc_addr), .wdata(acc_wdata), .rdata(acc_rdata)
    );

    // Purpose: register the read-valid and violation responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid  <= 1'b0;
            viol_valid  <= 1'b0;
            viol_tenant <= '0;
        end else begin
            acc_rvalid  <= go && !acc_write;
            viol_valid  <= go && !allowed;
            viol_tenant <= acc_tenant;
        end
    end
endmodule

// File: rtl/spm_guard_chk.sv
// Property checker for spm_guard, attached to it with bind. It only observes
// the ports of the top module.
module spm_guard_chk #(
    parameter int TW = 2,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic [TW-1:0] acc_tenant,
    input logic          acc_stall,
    input logic          acc_rvalid,
    input logic [DW-1:0] acc_rdata,
    input logic          viol_valid,
    input logic [TW-1:0] viol_tenant,
    input logic          claim_ack,
    input logic          claim_nack,
    input logic          zero_busy,
    input logic          zero_done
);
    // R4: a refused access returns zero data.
    p_zero_data_on_viol_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> acc_rdata == '0);

    // R4: the flagged tenant is the one that made the request.
    p_viol_tenant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> viol_tenant == $past(acc_tenant));

    // R9: a stalled access produces no response.
    p_stall_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_stall) |=> (!acc_rvalid && !viol_valid));

    // R6: done comes exactly when busy falls.
    p_done_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zero_busy) |-> zero_done);

    // R6: done is a single-cycle pulse.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_done |=> !zero_done);

    // R2: a claim is never both granted and refused.
    p_claim_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(claim_ack && claim_nack));
endmodule

bind spm_guard spm_guard_chk #(.TW(TW), .DW(DATA_W)) u_prop (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_tenant(acc_tenant),
    .acc_stall(acc_stall), .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
    .viol_valid(viol_valid), .viol_tenant(viol_tenant),
    .claim_ack(claim_ack), .claim_nack(claim_nack),
    .zero_busy(zero_busy), .zero_done(zero_done)
);

// File: tb/spm_guard_tb.sv
module spm_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int RG  = 8;
    localparam int WP  = 4;
    localparam int DW  = 16;
    localparam int TW  = 2;
    localparam int RIW = 3;
    localparam int WOW = 2;
    localparam int AW  = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic [NT*RIW-1:0] tenant_base, tenant_limit;
    logic claim_valid = 0; logic [TW-1:0] claim_tenant = 0; logic [RIW-1:0] claim_region = 0;
    logic claim_ack, claim_nack;
    logic acc_valid = 0, acc_write = 0; logic [TW-1:0] acc_tenant = 0;
    logic [AW-1:0] acc_addr = 0; logic [DW-1:0] acc_wdata = 0;
    logic acc_stall, acc_rvalid, viol_valid; logic [DW-1:0] acc_rdata; logic [TW-1:0] viol_tenant;
    logic zero_start = 0; logic [RIW-1:0] zero_first = 0, zero_last = 0; logic zero_teardown = 0;
    logic zero_busy, zero_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    spm_guard #(.NUM_TENANTS(NT), .REGIONS(RG), .WPR(WP), .DATA_W(DW)) u_dut (.*);

    // Bench model of the expected state
    bit          m_held [RG];
    int          m_own  [RG];
    logic [DW-1:0] m_mem [RG*WP];
    int          m_base [NT] = '{0, 2, 4, 0};
    int          m_lim  [NT] = '{1, 3, 5, 7};
    int          n_chk = 0, n_err = 0;
    bit          ended = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    function automatic bit exp_ok(input int t, input int a);
        int r = a / WP;
        return m_held[r] && m_own[r] == t && r >= m_base[t] && r <= m_lim[t];
    endfunction

    task automatic claim(input int t, input int r, input string req);
        bit exp = !m_held[r];
        @(negedge clk);
        claim_valid = 1; claim_tenant = TW'(t); claim_region = RIW'(r);
        @(negedge clk);
        claim_valid = 0;
        chk(claim_ack == exp && claim_nack == !exp, req, {claim_ack, claim_nack}, {exp, !exp});
        if (exp) begin m_held[r] = 1; m_own[r] = t; end
    endtask

    task automatic access(input int t, input int a, input bit w, input logic [DW-1:0] d, input string req);
        bit ok = exp_ok(t, a);
        @(negedge clk);
        acc_valid = 1; acc_write = w; acc_tenant = TW'(t); acc_addr = AW'(a); acc_wdata = d;
        #1 chk(acc_stall == 0, "R9", acc_stall, 0);
        @(negedge clk);
        acc_valid = 0;
        chk(viol_valid == !ok, req, viol_valid, !ok);
        if (!ok) chk(viol_tenant == TW'(t), "R4", viol_tenant, t);
        if (w) begin
            chk(acc_rvalid == 0, req, acc_rvalid, 0);
            if (ok) m_mem[a] = d;
        end else begin
            chk(acc_rvalid == 1, req, acc_rvalid, 1);
            chk(acc_rdata == (ok ? m_mem[a] : '0), req, acc_rdata, ok ? m_mem[a] : 0);
        end
    endtask

    task automatic zero_run(input int f, input int l, input bit tear);
        int cnt = 0;
        @(negedge clk);
        zero_start = 1; zero_first = RIW'(f); zero_last = RIW'(l); zero_teardown = tear;
        @(negedge clk);
        zero_start = 0;
        while (zero_busy && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == (l - f + 1) * WP, "R6 busy length", cnt, (l - f + 1) * WP);
        chk(zero_done == 1, "R6 done pulse", zero_done, 1);
        @(negedge clk);
        chk(zero_done == 0, "R6 done single", zero_done, 0);
        for (int a = f * WP; a < (l + 1) * WP; a++) m_mem[a] = '0;
        if (tear) for (int r = f; r <= l; r++) m_held[r] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int t = 0; t < NT; t++) begin
            tenant_base[t*RIW +: RIW]  = RIW'(m_base[t]);
            tenant_limit[t*RIW +: RIW] = RIW'(m_lim[t]);
        end
        for (int r = 0; r < RG; r++) begin m_held[r] = 0; m_own[r] = 0; end
        for (int a = 0; a < RG*WP; a++) m_mem[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!claim_ack && !claim_nack && !acc_rvalid && !viol_valid && !zero_busy && !zero_done,
            "R1 outputs", {claim_ack, claim_nack, acc_rvalid, viol_valid, zero_busy, zero_done}, 0);
        access(3, 5, 0, 0, "R1 unheld read");

        // R2: claims
        claim(0, 0, "R2 claim free"); claim(0, 1, "R2 claim free");
        claim(1, 2, "R2 claim free"); claim(1, 3, "R2 claim free");
        claim(2, 4, "R2 claim free"); claim(3, 6, "R2 claim free");
        claim(1, 7, "R2 claim free");
        claim(2, 0, "R2 claim held");
        claim(3, 2, "R2 claim held");

        // R3: holder access within window; R11: every tenant ID
        access(0, 1, 1, 16'hA001, "R3 write"); access(0, 1, 0, 0, "R3 read");
        access(1, 9, 1, 16'hB009, "R3 write"); access(1, 9, 0, 0, "R3 read");
        access(2, 17, 1, 16'hC011, "R11 tenant2"); access(2, 17, 0, 0, "R11 tenant2");
        access(3, 25, 1, 16'hD019, "R11 tenant3"); access(3, 25, 0, 0, "R11 tenant3");
        // R4: other tenant's region, and a free region
        access(3, 1, 0, 0, "R4 foreign read"); access(3, 1, 1, 16'hFFFF, "R4 foreign write");
        access(0, 1, 0, 0, "R4 memory unchanged");
        access(2, 20, 1, 16'h1234, "R4 free region");
        // R5: held by the tenant but outside its window
        access(1, 28, 1, 16'h5555, "R5 out of window");
        access(1, 28, 0, 0, "R5 out of window");

        // R9: stall during a running clear and in the acceptance cycle
        @(negedge clk);
        zero_start = 1; zero_first = 0; zero_last = 1; zero_teardown = 0;
        acc_valid = 1; acc_write = 0; acc_tenant = 0; acc_addr = 2;
        #1 chk(acc_stall == 1, "R9 stall on accept", acc_stall, 1);
        @(negedge clk);
        zero_start = 0;
        #1 chk(acc_stall == 1, "R9 stall while busy", acc_stall, 1);
        @(negedge clk);
        chk(acc_rvalid == 0 && viol_valid == 0, "R9 no response", {acc_rvalid, viol_valid}, 0);
        // R10: second request while busy is ignored (region 4 stays intact)
        zero_start = 1; zero_first = 4; zero_last = 4; acc_valid = 0;
        @(negedge clk);
        zero_start = 0;
        acc_valid = 1; acc_tenant = 1; acc_addr = 9; acc_write = 0;
        #1 chk(acc_stall == 0, "R9 outside span", acc_stall, 0);
        @(negedge clk);
        acc_valid = 0;
        chk(acc_rvalid && acc_rdata == 16'hB009, "R9 outside span read", acc_rdata, 16'hB009);
        while (zero_busy) @(negedge clk);
        for (int a = 0; a < 2*WP; a++) m_mem[a] = '0;
        access(0, 1, 0, 0, "R7 cleared reads zero");
        access(2, 17, 0, 0, "R10 busy request ignored");
        // R10: reversed range ignored
        @(negedge clk);
        zero_start = 1; zero_first = 5; zero_last = 4;
        @(negedge clk);
        zero_start = 0;
        chk(zero_busy == 0, "R10 reversed range", zero_busy, 0);

        // R6/R7: clear without teardown keeps the holder
        access(2, 18, 1, 16'h7777, "R3 write");
        zero_run(4, 4, 0);
        access(2, 18, 0, 0, "R7 zero after clear");
        access(2, 19, 1, 16'h4242, "R7 holder kept");
        access(2, 19, 0, 0, "R7 holder kept");

        // R8: teardown clears ownership
        zero_run(2, 3, 1);
        access(1, 9, 0, 0, "R8 former holder blocked");
        claim(3, 2, "R8 reclaim after teardown");
        access(3, 9, 0, 0, "R8 reads zero after reclaim");

        // Randomized traffic
        for (int i = 0; i < 400; i++) begin
            int t = $urandom_range(0, NT-1);
            int a = $urandom_range(0, RG*WP-1);
            bit w = $urandom_range(0, 1);
            access(t, a, w, DW'($urandom), w ? "R3/R4/R5 random write" : "R3/R4/R5 random read");
        end
        finish_run();
    end
endmodule